// File: doc/BRIEF.md
# Interrupt Source Mode Gateway

This block sits at the input side of a platform interrupt controller. Each interrupt source drives one raw wire into it. The block turns that wire into a sticky pending bit. How it does so depends on a 3-bit trigger-mode field and a delegation flag, both supplied by a separate register block. For the edge modes, each source keeps its previous wire level so that edges can be detected.

A single domain-wide enable gates all of this activity. While that enable is low, or while a source is delegated elsewhere, its pending bit cannot be set and its stored level is frozen. Each source also has a per-source enable. When a source is both enabled and pending, the block raises its notify output so that downstream delivery logic can act.

The register block clears pending bits through a synchronous per-source clear input. If a clear and a set land in the same cycle, the clear wins. Sources are numbered from 1. Slot 0 of each output vector exists only to keep the numbering aligned, and it is tied to zero.

Top module: `irq_src_gateway`

## Requirements
- R1: With mode 4 (rising edge), the pending bit is set at the next clock edge when the wire is 1 and the stored previous level is 0.
- R2: With mode 5 (falling edge), the pending bit is set at the next clock edge when the wire is 0 and the stored previous level is 1.
- R3: With mode 6 the pending bit is set whenever the wire is 1, and with mode 7 it is set whenever the wire is 0, each at the next clock edge.
- R4: Modes 0 (inactive) and 1 (detached) never set the pending bit, but the stored previous level still follows the wire.
- R5: Modes 2 and 3 are reserved. They never set the pending bit, and the same-cycle output mode_err for that source is 1 while the domain enable is 1 and the source is not delegated. The stored level still follows the wire.
- R6: While a source's delegate input is 1, its pending bit is not set and its stored previous level does not change.
- R7: While dom_en is 0, no pending bit is set and no stored previous level changes.
- R8: notify[k] is 1 exactly when src_en[k] and pend[k] are both 1, in the same cycle.
- R9: A pending bit stays set until clr_pend for that source is 1. clr_pend clears the bit at the next edge even if a set condition is present in that same cycle.
- R10: Bit 0 of pend, notify and mode_err is always 0. Source k (1..NUM_SRC) uses input bit k and mode field src_mode[3*(k-1)+2 : 3*(k-1)].
- R11: After reset, all pending bits and all stored previous levels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| dom_en | input | 1 | Domain-wide interrupt enable |
| wire_lvl | input | NUM_SRC (bits NUM_SRC:1) | Raw source wire levels |
| src_mode | input | 3*NUM_SRC | Trigger-mode fields, 3 bits per source |
| src_deleg | input | NUM_SRC (bits NUM_SRC:1) | Delegation flags |
| src_en | input | NUM_SRC (bits NUM_SRC:1) | Per-source enables |
| clr_pend | input | NUM_SRC (bits NUM_SRC:1) | Synchronous pending clear |
| pend | output | NUM_SRC+1 | Pending bits, bit 0 is 0 |
| notify | output | NUM_SRC+1 | Enabled and pending, bit 0 is 0 |
| mode_err | output | NUM_SRC+1 | Reserved-mode flag, bit 0 is 0 |

## Verification
The main stimulus is a series of phases in which every source is assigned a different trigger mode and the mode assignment rotates from one phase to the next, so every source passes through all eight encodings while random wire levels are applied. Because the previous level carries over from one phase into the next, an edge that follows an inactive, detached or reserved phase shows whether the stored level kept tracking the wire. Phases with a toggling domain enable and with random delegation show whether those two gates freeze both the set path and the stored level. Sparse random clears, plus one directed cycle in which a clear and a level-high set coincide, separate a sticky pending bit from a clear-priority fault.

// File: rtl/gw_pkg.sv
package gw_pkg;

  typedef enum logic [2:0] {
    SM_OFF    = 3'd0,
    SM_DETACH = 3'd1,
    SM_RSV_A  = 3'd2,
    SM_RSV_B  = 3'd3,
    SM_RISE   = 3'd4,
    SM_FALL   = 3'd5,
    SM_HIGH   = 3'd6,
    SM_LOW    = 3'd7
  } src_mode_e;

  localparam int MODE_W = 3;

  function automatic logic mode_reserved(input logic [MODE_W-1:0] m);
    return (m == SM_RSV_A) || (m == SM_RSV_B);
  endfunction

  // Trigger decision from current wire level and remembered level.
  function automatic logic trig_hit(input logic [MODE_W-1:0] m,
                                    input logic lvl,
                                    input logic prev);
    logic hit;
    unique case (src_mode_e'(m))
      SM_RISE: hit = lvl & ~prev;
      SM_FALL: hit = ~lvl & prev;
      SM_HIGH: hit = lvl;
      SM_LOW:  hit = ~lvl;
      default: hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/gw_trigger_eval.sv
module gw_trigger_eval
  import gw_pkg::*;
(
  input  logic              dom_en,
  input  logic              deleg,
  input  logic [MODE_W-1:0] mode,
  input  logic              lvl,
  input  logic              prev,
  output logic              set_req,
  output logic              hist_we,
  output logic              rsv_err
);
  logic active;

  assign active  = dom_en & ~deleg;
  assign set_req = active & trig_hit(mode, lvl, prev);
  assign hist_we = active;
  assign rsv_err = active & mode_reserved(mode);
endmodule

// File: rtl/gw_source_cell.sv
module gw_source_cell
  import gw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dom_en,
  input  logic              deleg,
  input  logic [MODE_W-1:0] mode,
  input  logic              lvl,
  input  logic              clr,
  output logic              pend_q,
  output logic              hist_q,
  output logic              set_evt,
  output logic              rsv_err
);
  logic hist_we;

  gw_trigger_eval u_eval (
    .dom_en  (dom_en),
    .deleg   (deleg),
    .mode    (mode),
    .lvl     (lvl),
    .prev    (hist_q),
    .set_req (set_evt),
    .hist_we (hist_we),
    .rsv_err (rsv_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      if (hist_we) hist_q <= lvl;
      // clear outranks a same-cycle set
      pend_q <= clr ? 1'b0 : (pend_q | set_evt);
    end
  end
endmodule

// File: rtl/irq_src_gateway.sv
module irq_src_gateway
  import gw_pkg::*;
#(
  parameter int NUM_SRC = 63
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      dom_en,
  input  logic [NUM_SRC:1]          wire_lvl,
  input  logic [MODE_W*NUM_SRC-1:0] src_mode,
  input  logic [NUM_SRC:1]          src_deleg,
  input  logic [NUM_SRC:1]          src_en,
  input  logic [NUM_SRC:1]          clr_pend,
  output logic [NUM_SRC:0]          pend,
  output logic [NUM_SRC:0]          notify,
  output logic [NUM_SRC:0]          mode_err
);
  // internal events exposed for the checker
  logic [NUM_SRC:1] set_evt;
  logic [NUM_SRC:1] hist_vec;

  assign pend[0]     = 1'b0;
  assign notify[0]   = 1'b0;
  assign mode_err[0] = 1'b0;

  for (genvar k = 1; k <= NUM_SRC; k++) begin : g_src
    gw_source_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .dom_en  (dom_en),
      .deleg   (src_deleg[k]),
      .mode    (src_mode[MODE_W*(k-1) +: MODE_W]),
      .lvl     (wire_lvl[k]),
      .clr     (clr_pend[k]),
      .pend_q  (pend[k]),
      .hist_q  (hist_vec[k]),
      .set_evt (set_evt[k]),
      .rsv_err (mode_err[k])
    );
    assign notify[k] = src_en[k] & pend[k];
  end
endmodule

// File: rtl/irq_src_gateway_chk.sv
module irq_src_gateway_chk
  import gw_pkg::*;
#(
  parameter int NUM_SRC = 63
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      dom_en,
  input logic [NUM_SRC:1]          wire_lvl,
  input logic [MODE_W*NUM_SRC-1:0] src_mode,
  input logic [NUM_SRC:1]          src_deleg,
  input logic [NUM_SRC:1]          clr_pend,
  input logic [NUM_SRC:0]          pend,
  input logic [NUM_SRC:0]          notify,
  input logic [NUM_SRC:0]          mode_err,
  input logic [NUM_SRC:1]          set_evt,
  input logic [NUM_SRC:1]          hist_vec
);
  a_r10_slot0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !pend[0] && !notify[0] && !mode_err[0]);

  for (genvar k = 1; k <= NUM_SRC; k++) begin : g_chk
    a_r7_off_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      !dom_en && !pend[k] |=> !pend[k]);
    a_r7_off_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !dom_en |=> $stable(hist_vec[k]));
    a_r6_deleg_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      src_deleg[k] && !pend[k] |=> !pend[k]);
    a_r6_deleg_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
      src_deleg[k] |=> $stable(hist_vec[k]));
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pend[k] |=> !pend[k]);
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[k] || set_evt[k]) && !clr_pend[k] |=> pend[k]);
    a_r1_rise: assert property (@(posedge clk) disable iff (!rst_n)
      dom_en && !src_deleg[k] && !clr_pend[k] &&
      src_mode[MODE_W*(k-1) +: MODE_W] == SM_RISE && wire_lvl[k] && !hist_vec[k]
      |=> pend[k]);
    a_r5_rsv_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err[k] |-> !set_evt[k]);
  end
endmodule

bind irq_src_gateway irq_src_gateway_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dom_en    (dom_en),
  .wire_lvl  (wire_lvl),
  .src_mode  (src_mode),
  .src_deleg (src_deleg),
  .clr_pend  (clr_pend),
  .pend      (pend),
  .notify    (notify),
  .mode_err  (mode_err),
  .set_evt   (set_evt),
  .hist_vec  (hist_vec)
);

// File: tb/irq_src_gateway_tb.sv
module irq_src_gateway_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 63;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            dom_en = 1'b0;
  logic [N:1]      wire_lvl = '0;
  logic [3*N-1:0]  src_mode = '0;
  logic [N:1]      src_deleg = '0;
  logic [N:1]      src_en = '0;
  logic [N:1]      clr_pend = '0;
  logic [N:0]      pend, notify, mode_err;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] rng = 32'h1234_abcd;
  bit m_pend [0:N];
  bit m_hist [0:N];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_src_gateway #(.NUM_SRC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .dom_en(dom_en), .wire_lvl(wire_lvl),
    .src_mode(src_mode), .src_deleg(src_deleg), .src_en(src_en),
    .clr_pend(clr_pend), .pend(pend), .notify(notify), .mode_err(mode_err)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] v = s;
    v = v ^ (v << 13);
    v = v ^ (v >> 17);
    v = v ^ (v << 5);
    return v;
  endfunction

  // bit 2: triggering mode, bit 1: level vs edge, bit 0: active-low sense
  function automatic bit model_hit(input logic [2:0] m, input bit l, input bit h);
    bit le = l ^ m[0];
    bit pe = h ^ m[0];
    if (!m[2]) return 1'b0;
    return m[1] ? le : (le && !pe);
  endfunction

  function automatic string tag_of(input int k, input logic [2:0] m);
    if (k == 0) return "R10";
    if (clr_pend[k]) return "R9";
    if (!dom_en) return "R7";
    if (src_deleg[k]) return "R6";
    case (m)
      3'd4: return "R1";
      3'd5: return "R2";
      3'd6, 3'd7: return "R3";
      3'd2, 3'd3: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string tag, input int k, input string what,
                     input bit act, input bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s src=%0d %s actual=%0b expected=%0b", tag, k, what, act, exp);
    end
  endtask

  // Inputs already driven; compare, advance one clock, update model.
  task automatic step();
    #1;
    for (int k = 0; k <= N; k++) begin
      logic [2:0] m = (k == 0) ? 3'd0 : src_mode[3*(k-1) +: 3];
      bit ep = (k == 0) ? 1'b0 : m_pend[k];
      bit ee = (k != 0) && dom_en && !src_deleg[k] && (m == 3'd2 || m == 3'd3);
      bit en = (k == 0) ? 1'b0 : src_en[k];
      chk(tag_of(k, m), k, "pend", pend[k], ep);
      chk((k == 0) ? "R10" : "R8", k, "notify", notify[k], en && ep);
      chk((k == 0) ? "R10" : "R5", k, "mode_err", mode_err[k], ee);
    end
    @(posedge clk);
    for (int k = 1; k <= N; k++) begin
      logic [2:0] m = src_mode[3*(k-1) +: 3];
      bit s = 1'b0;
      if (dom_en && !src_deleg[k]) begin
        s = model_hit(m, wire_lvl[k], m_hist[k]);
        m_hist[k] = wire_lvl[k];
      end
      m_pend[k] = clr_pend[k] ? 1'b0 : (m_pend[k] || s);
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k <= N; k++) begin m_pend[k] = 0; m_hist[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state of pending and notify
    for (int k = 0; k <= N; k++) begin
      chk("R11", k, "pend after reset", pend[k], 1'b0);
      chk("R11", k, "notify after reset", notify[k], 1'b0);
    end
    // R11: stored level is 0, so a high wire in rising mode must set pending
    dom_en = 1'b1;
    for (int k = 1; k <= N; k++) src_mode[3*(k-1) +: 3] = 3'd4;
    wire_lvl = '1;
    src_en = '1;
    step();
    for (int k = 1; k <= N; k++) chk("R11", k, "rise after reset", pend[k], 1'b1);
    clr_pend = '1;
    step();
    clr_pend = '0;

    // Rotating-mode phases: p=3 toggles dom_en, p>=5 random delegation
    for (int p = 0; p < 8; p++) begin
      for (int k = 1; k <= N; k++) src_mode[3*(k-1) +: 3] = 3'((k + p) % 8);
      for (int c = 0; c < 300; c++) begin
        rng = nxt(rng); wire_lvl[31:1] = rng[30:0];
        rng = nxt(rng); wire_lvl[N:32] = rng[N-32:0];
        rng = nxt(rng);
        dom_en = (p == 3) ? rng[0] : 1'b1;
        rng = nxt(rng);
        for (int k = 1; k <= N; k++) begin
          rng = nxt(rng);
          clr_pend[k]  = (rng[2:0] == 3'd0);
          src_deleg[k] = (p >= 5) ? rng[7] : 1'b0;
          src_en[k]    = rng[11] | rng[12];
        end
        step();
      end
    end

    // R9 directed: level-high set coinciding with clear on source 7
    dom_en = 1'b1; src_deleg = '0; clr_pend = '1;
    step();
    clr_pend = '0;
    src_mode = '0;
    src_mode[3*6 +: 3] = 3'd6;
    wire_lvl = '0; wire_lvl[7] = 1'b1;
    clr_pend[7] = 1'b1;
    step();
    chk("R9", 7, "clear beats set", pend[7], 1'b0);
    clr_pend[7] = 1'b0;
    step();
    chk("R9", 7, "set after clear released", pend[7], 1'b1);
    wire_lvl[7] = 1'b0;
    step();
    chk("R9", 7, "sticky after wire drop", pend[7], 1'b1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule